// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block converts between a 36-bit storage word and the narrower 18-bit or 9-bit words seen at a buffer's external port. It uses one clock. When it sits in front of a store, it packs two or four narrow words into one full storage word. When it sits behind a store, it unpacks one storage word into two or four narrow words, which come out on successive cycles. A straight 36-to-36 path is also available, and it adds one register stage.

The width pairing and the slice order are configuration pins. They are captured only while master reset is held, and they stay fixed until the next master reset. In big-endian order the most significant slice goes first in time. In little-endian order the least significant slice goes first. A partial reset throws away any half-built word or any slices not yet sent, and it keeps the captured configuration. While the unpacker is still emitting the slices of a word, it holds off the next wide word.

Top module: `mwc_bus_match`

## Requirements
- R1: `cfg_mode` encodes the width pairing as follows: 0 = 36→36, 1 = 36→18, 2 = 36→9, 3 = 18→36, 4 = 9→36. The values 5, 6 and 7 behave exactly as 36→36.
- R2: `cfg_mode` and `cfg_big_end` are sampled on each clock edge while `mrst_n` is low. Changes on these pins while `mrst_n` is high have no effect on the output.
- R3: In 36→36 mode, a word accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high in the following cycle, for exactly one cycle.
- R4: In 36→18 mode, an accepted word produces 2 outputs. In 36→9 mode it produces 4 outputs. These come out on consecutive cycles, starting the cycle after acceptance. Each output sits in `out_data` bits [W-1:0], where W is 18 or 9, and all bits above it are zero.
- R5: With `cfg_big_end`=1, the k-th slice sent (counting from k=0) of an N-slice word is bits [(N-1-k)·W +: W]. In packing modes, the k-th narrow input lands at that same position.
- R6: With `cfg_big_end`=0, the k-th slice (counting from k=0) is bits [k·W +: W], for both unpacking and packing.
- R7: In 18→36 and 9→36 modes, each cycle with `in_valid` high takes one narrow word from `in_data` bits [W-1:0] and ignores the upper bits. The full word appears with `out_valid` high for one cycle, in the cycle after the 2nd or 4th narrow word is taken.
- R8: In unpacking and pass modes, `in_ready` is low while a word still has more than one slice left to send. It is high during the cycle its last slice is shown, so the next word follows with no gap. In packing modes, `in_ready` is always high.
- R9: A clock edge with `prst_n` low discards any partial word and any unsent slices. `out_valid` is low in the following cycle. The captured configuration is kept.
- R10: After a clock edge with `mrst_n` low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, synchronous, active low; captures configuration |
| prst_n | input | 1 | Partial reset, synchronous, active low; keeps configuration |
| cfg_mode | input | 3 | Width pairing select, sampled during master reset |
| cfg_big_end | input | 1 | Slice order select, 1 = most significant first |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word will be taken on this edge |
| in_data | input | WORD_W | Input word; narrow modes use the low bits |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | WORD_W | Output word; narrow modes drive the low bits |

## Verification
Every legal pairing is run with both slice orders. The input stream varies from sparse to fully back-to-back. Sparse traffic confirms that slices keep coming while the input is idle. Continuous traffic confirms that the unpacker accepts a new word exactly in its last-slice cycle and leaves no bubble. Narrow inputs carry random upper bits, which shows whether those bits are ignored. Partial resets are applied in the middle of a word in both directions. Configuration pins are changed after reset, and illegal mode codes are tried; together these distinguish captured settings from live pins.

// File: rtl/mwc_pkg.sv
// Shared types and helpers for the bus-matching width converter.
// Assumes the storage word splits evenly into four quarter slices.
package mwc_pkg;

    typedef enum logic [2:0] {
        MWC_W2W = 3'd0,
        MWC_W2H = 3'd1,
        MWC_W2Q = 3'd2,
        MWC_H2W = 3'd3,
        MWC_Q2W = 3'd4
    } mwc_mode_e;

    // Map a raw pin code to a legal pairing; unknown codes fall back to pass-through.
    function automatic mwc_mode_e mwc_legalize(input logic [2:0] raw);
        return (raw <= 3'd4) ? mwc_mode_e'(raw) : MWC_W2W;
    endfunction

    // Index of the last slice of one storage word (slices minus one).
    function automatic logic [1:0] mwc_last_idx(input mwc_mode_e m);
        case (m)
            MWC_W2H, MWC_H2W: return 2'd1;
            MWC_W2Q, MWC_Q2W: return 2'd3;
            default:          return 2'd0;
        endcase
    endfunction

    // True when narrow port words are gathered into storage words.
    function automatic logic mwc_is_pack(input mwc_mode_e m);
        return (m == MWC_H2W) || (m == MWC_Q2W);
    endfunction

    // True when the narrow side is a half word rather than a quarter word.
    function automatic logic mwc_is_half(input mwc_mode_e m);
        return (m == MWC_W2H) || (m == MWC_H2W);
    endfunction

endpackage

// File: rtl/mwc_cfg.sv
// Configuration capture: samples the pairing and slice-order pins on every
// edge while master reset is low and holds them otherwise.
// Assumes the pins are stable in the last reset cycle.
module mwc_cfg
    import mwc_pkg::*;
(
    input  logic       clk,
    input  logic       mrst_n,
    input  logic [2:0] pin_mode,
    input  logic       pin_big,
    output mwc_mode_e  mode_q,
    output logic       big_q
);

    // Load the settings only while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= mwc_legalize(pin_mode);
            big_q  <= pin_big;
        end
    end

endmodule

// File: rtl/mwc_unpack.sv
// Unpacker: takes one storage word and emits it as 1, 2 or 4 slices on
// consecutive cycles. Ready rises in the last-slice cycle for gapless flow.
// Assumes last_idx and half change only while rst_n is low.
module mwc_unpack #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        last_idx,
    input  logic              half,
    input  logic              big,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    localparam int H = WORD_W / 2;
    localparam int Q = WORD_W / 4;

    logic [WORD_W-1:0] hold;
    logic [1:0]        cnt;
    logic              busy;
    logic [1:0]        pos;
    logic              take;

    assign wr_ready = !busy || (cnt == last_idx);
    assign take     = wr_valid && wr_ready;
    assign rd_valid = busy;

    // Capture a new word or step through the slices of the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (take) begin
            hold <= wr_data;
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == last_idx) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 2'd1;
            end
        end
    end

    // Select the slice for the current step according to the slice order.
    always_comb begin
        pos     = big ? (last_idx - cnt) : cnt;
        rd_data = '0;
        if (last_idx == 2'd0) begin
            rd_data = hold;
        end else if (half) begin
            rd_data[H-1:0] = hold[H*pos[0] +: H];
        end else begin
            rd_data[Q-1:0] = hold[Q*pos +: Q];
        end
    end

endmodule

// File: rtl/mwc_pack.sv
// Packer: gathers 2 or 4 narrow words into one storage word and presents
// it for one cycle after the final slice. Upper input bits are ignored.
// Assumes last_idx and half change only while rst_n is low.
module mwc_pack #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        last_idx,
    input  logic              half,
    input  logic              big,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              st_valid,
    output logic [WORD_W-1:0] st_data
);

    localparam int H = WORD_W / 2;
    localparam int Q = WORD_W / 4;

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic [1:0]        cnt;
    logic [1:0]        pos;

    // Place the incoming narrow word at its slot in the partial word.
    always_comb begin
        pos    = big ? (last_idx - cnt) : cnt;
        merged = acc;
        if (last_idx == 2'd0) begin
            merged = wr_data;
        end else if (half) begin
            merged[H*pos[0] +: H] = wr_data[H-1:0];
        end else begin
            merged[Q*pos +: Q] = wr_data[Q-1:0];
        end
    end

    // Accumulate slices and emit the finished word as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            cnt      <= '0;
            st_valid <= 1'b0;
            st_data  <= '0;
        end else begin
            st_valid <= 1'b0;
            if (wr_valid) begin
                if (cnt == last_idx) begin
                    st_data  <= merged;
                    st_valid <= 1'b1;
                    acc      <= '0;
                    cnt      <= '0;
                end else begin
                    acc <= merged;
                    cnt <= cnt + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/mwc_bus_match.sv
// Bus-matching width converter top: captures the pairing at master reset
// and steers traffic through either the packer or the unpacker.
// Assumes WORD_W is a multiple of four; both resets are synchronous.
module mwc_bus_match
    import mwc_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_big_end,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    mwc_mode_e         cfg_mode_q;
    logic              cfg_big_q;
    logic              dp_rst_n;
    logic [1:0]        last_idx;
    logic              is_pack;
    logic              is_half;
    logic              up_ready;
    logic              up_valid;
    logic [WORD_W-1:0] up_data;
    logic              pk_valid;
    logic [WORD_W-1:0] pk_data;

    assign dp_rst_n = mrst_n && prst_n;
    assign last_idx = mwc_last_idx(cfg_mode_q);
    assign is_pack  = mwc_is_pack(cfg_mode_q);
    assign is_half  = mwc_is_half(cfg_mode_q);

    mwc_cfg u_cfg (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .pin_mode (cfg_mode),
        .pin_big  (cfg_big_end),
        .mode_q   (cfg_mode_q),
        .big_q    (cfg_big_q)
    );

    mwc_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk      (clk),
        .rst_n    (dp_rst_n),
        .last_idx (last_idx),
        .half     (is_half),
        .big      (cfg_big_q),
        .wr_valid (in_valid && !is_pack),
        .wr_data  (in_data),
        .wr_ready (up_ready),
        .rd_valid (up_valid),
        .rd_data  (up_data)
    );

    mwc_pack #(.WORD_W(WORD_W)) u_pack (
        .clk      (clk),
        .rst_n    (dp_rst_n),
        .last_idx (last_idx),
        .half     (is_half),
        .big      (cfg_big_q),
        .wr_valid (in_valid && is_pack),
        .wr_data  (in_data),
        .st_valid (pk_valid),
        .st_data  (pk_data)
    );

    // Route the active direction to the block's ports.
    always_comb begin
        in_ready  = is_pack ? 1'b1 : up_ready;
        out_valid = is_pack ? pk_valid : up_valid;
        out_data  = is_pack ? pk_data : up_data;
    end

endmodule

// File: rtl/mwc_bus_match_chk.sv
// Checker for the bus-matching width converter, bound to the top module.
module mwc_bus_match_chk
    import mwc_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              mrst_n,
    input logic              prst_n,
    input mwc_mode_e         mode_q,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data
);

    localparam int H = WORD_W / 2;
    localparam int Q = WORD_W / 4;

    logic gathers;
    assign gathers = (mode_q == MWC_H2W) || (mode_q == MWC_Q2W);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> $stable(mode_q));

    // R8
    pack_ready_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        gathers |-> in_ready);

    // R3
    accept_out_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!gathers && in_valid && in_ready) |=> out_valid);

    // R4
    quarter_zero_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (out_valid && mode_q == MWC_W2Q) |-> (out_data[WORD_W-1:Q] == '0));

    // R4
    half_zero_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (out_valid && mode_q == MWC_W2H) |-> (out_data[WORD_W-1:H] == '0));

    // R9
    prst_flush_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> !out_valid);

    // R7
    pack_gap_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (gathers && out_valid) |=> !out_valid);

endmodule

bind mwc_bus_match mwc_bus_match_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .mode_q    (cfg_mode_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_mwc_bus_match.sv
module sim_mwc_bus_match;

    localparam int CLK_PERIOD = 10;
    localparam int WW = 36;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic [2:0]    cfg_mode = 3'd0;
    logic          cfg_big_end = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [WW-1:0] in_data = '0;
    logic          out_valid;
    logic [WW-1:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    string tag = "R10";

    // behavioural reference state
    int            m_mode = 0;
    bit            m_big = 1'b0;
    logic [WW-1:0] m_slices[$];
    int            m_pk_cnt = 0;
    logic [WW-1:0] m_pk_word = '0;
    bit            m_pk_valid = 1'b0;
    logic [WW-1:0] m_pk_data = '0;
    bit            known = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwc_bus_match #(.WORD_W(WW)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_mode(cfg_mode), .cfg_big_end(cfg_big_end),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int n_of(int m);
        if (m == 1 || m == 3) return 2;
        if (m == 2 || m == 4) return 4;
        return 1;
    endfunction

    function automatic bit packing(int m);
        return (m == 3 || m == 4);
    endfunction

    function automatic logic [WW-1:0] low_mask(int w);
        logic [WW-1:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = 1'b1;
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare outputs against the model, then apply inputs and advance the model
    task automatic cycle(bit mr, bit pr, bit v, logic [WW-1:0] d);
        bit            e_ready;
        bit            e_valid;
        logic [WW-1:0] e_data;
        int            n;
        int            w;
        int            pos;
        @(negedge clk);
        if (known) begin
            e_ready = packing(m_mode) ? 1'b1 : (m_slices.size() <= 1);
            e_valid = packing(m_mode) ? m_pk_valid : (m_slices.size() > 0);
            e_data  = packing(m_mode) ? m_pk_data : ((m_slices.size() > 0) ? m_slices[0] : '0);
            chk(in_ready === e_ready, "R8", "in_ready", WW'(in_ready), WW'(e_ready));
            chk(out_valid === e_valid, tag, "out_valid", WW'(out_valid), WW'(e_valid));
            if (e_valid) chk(out_data === e_data, tag, "out_data", out_data, e_data);
        end
        mrst_n = mr; prst_n = pr; in_valid = v; in_data = d;
        e_ready = packing(m_mode) ? 1'b1 : (m_slices.size() <= 1);
        if (!mr) begin
            m_mode = (cfg_mode <= 3'd4) ? int'(cfg_mode) : 0;
            m_big  = cfg_big_end;
            m_slices.delete(); m_pk_cnt = 0; m_pk_word = '0; m_pk_valid = 1'b0;
        end else if (!pr) begin
            m_slices.delete(); m_pk_cnt = 0; m_pk_word = '0; m_pk_valid = 1'b0;
        end else begin
            n = n_of(m_mode);
            w = WW / n;
            if (packing(m_mode)) begin
                m_pk_valid = 1'b0;
                if (v) begin
                    pos = m_big ? (n - 1 - m_pk_cnt) : m_pk_cnt;
                    m_pk_word = m_pk_word | ((d & low_mask(w)) << (pos * w));
                    m_pk_cnt++;
                    if (m_pk_cnt == n) begin
                        m_pk_valid = 1'b1; m_pk_data = m_pk_word;
                        m_pk_cnt = 0; m_pk_word = '0;
                    end
                end
            end else begin
                if (m_slices.size() > 0) void'(m_slices.pop_front());
                if (v && e_ready) begin
                    for (int k = 0; k < n; k++) begin
                        pos = m_big ? (n - 1 - k) : k;
                        m_slices.push_back((d >> (pos * w)) & low_mask(w));
                    end
                end
            end
        end
        known = 1'b1;
    endtask

    function automatic logic [WW-1:0] rnd36();
        return {4'($urandom()), $urandom()};
    endfunction

    task automatic traffic(int cycles, int density);
        for (int i = 0; i < cycles; i++)
            cycle(1'b1, 1'b1, (($urandom() % 100) < density), rnd36());
    endtask

    // master reset with given pins; the first idle cycle after it checks R10
    task automatic do_reset(int mode, bit big);
        cfg_mode = 3'(mode); cfg_big_end = big;
        tag = "R10";
        cycle(1'b0, 1'b1, 1'b1, rnd36());
        cycle(1'b0, 1'b1, 1'b0, '0);
        cycle(1'b1, 1'b1, 1'b0, '0);
    endtask

    initial begin
        do_reset(0, 0);  tag = "R3"; traffic(40, 70);
        do_reset(1, 1);  tag = "R5"; traffic(50, 60); traffic(20, 100);
        do_reset(2, 1);  tag = "R5"; traffic(60, 80);
        do_reset(1, 0);  tag = "R6"; traffic(40, 100);
        do_reset(2, 0);  tag = "R6"; traffic(60, 50);
        do_reset(3, 1);  tag = "R7"; traffic(50, 70);
        do_reset(3, 0);  tag = "R7"; traffic(50, 100);
        do_reset(4, 1);  tag = "R7"; traffic(60, 100);
        do_reset(4, 0);  tag = "R7"; traffic(60, 60);
        // R4: narrow unpack with continuous input
        do_reset(2, 1);  tag = "R4"; traffic(40, 100);
        // R2: pins move after reset, captured settings must persist
        do_reset(2, 1);  tag = "R2";
        cfg_mode = 3'd4; cfg_big_end = 1'b0;
        traffic(60, 80);
        // R9: partial reset in the middle of a packed word
        do_reset(4, 1);  tag = "R7";
        cycle(1'b1, 1'b1, 1'b1, rnd36());
        cycle(1'b1, 1'b1, 1'b1, rnd36());
        tag = "R9";
        cycle(1'b1, 1'b0, 1'b1, rnd36());
        traffic(30, 100);
        // R9: partial reset while slices are still being sent
        do_reset(2, 0);  tag = "R6";
        cycle(1'b1, 1'b1, 1'b1, rnd36());
        cycle(1'b1, 1'b1, 1'b0, '0);
        tag = "R9";
        cycle(1'b1, 1'b0, 1'b0, '0);
        traffic(30, 70);
        // R1: illegal codes act as pass-through
        do_reset(6, 1);  tag = "R1"; traffic(40, 80);
        do_reset(7, 0);  tag = "R1"; traffic(30, 100);
        cycle(1'b1, 1'b1, 1'b0, '0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule